// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block is the host-side master for a successive-approximation converter that delivers its result over a three-wire serial link (active-low select, serial clock, serial data). A one-cycle start request begins a frame. The block lowers select and produces the serial clock from the system clock through a programmable divider. It samples the data line on each rising serial-clock edge. The first two clocks are the converter's acquisition period and carry no data. The third carries a bit that must be zero. After that the 12-bit two's-complement result arrives most significant bit first.

Two options reduce power or add protection. A frame can be cut short after a programmable number of result bits, so select returns high sooner and the converter powers down earlier. With all twelve bits requested, the block can also keep clocking through the converter's reversed repeat of the word and compare every repeated bit with the copy already captured. Each frame ends with a one-cycle valid pulse that presents the result, left-aligned and sign-extended, together with an error flag. Select then stays high for at least one full serial-clock period before the next frame may begin.

Top module: `scr_reader`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, and busy_o, valid_o, error_o, result_o and result_sx_o are all 0.
- R2: Each serial-clock half period lasts div_i+1 system clocks. sclk_o is low when cs_n_o falls, and the first rising edge comes one half period later.
- R3: Rising serial-clock edge k is counted from 1 after cs_n_o falls. Edges 4 to 15 carry result bits 11 down to 0. The assembled value appears on result_o as two's complement (800h is most negative, 7FFh is most positive), and result_sx_o is that value sign-extended to 16 bits.
- R4: The bit count N is nbits_i limited to the range 3 to 12. Values below 3 count as 3 and values above 12 count as 12. Exactly N+3 rising edges occur while cs_n_o is low, and cs_n_o rises one half period after the last of them. The result bits that were not read are 0 in result_o.
- R5: When mirror_i is 1 and N is 12, the frame continues to 26 rising edges. Edges 16 to 26 must carry bits 1 to 11 of the word, and any mismatch sets error_o. When N is below 12, mirror_i has no effect on the edge count or on error_o.
- R6: If the data line reads 1 on rising edge 3, error_o is set for that frame.
- R7: valid_o is a one-cycle pulse in the cycle where cs_n_o rises. result_o, result_sx_o and error_o keep their values until the next valid_o.
- R8: A start request is accepted only while busy_o is 0, and a request during a frame is dropped, not queued. Between the end of one frame and the next fall of cs_n_o, cs_n_o stays high for at least 2*(div_i+1) system clocks.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a frame |
| div_i | input | 8 | Serial half period in system clocks, minus one |
| nbits_i | input | 4 | Number of result bits to read (limited to 3..12) |
| mirror_i | input | 1 | Also read and check the reversed repeat |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | Frame or post-frame guard in progress |
| valid_o | output | 1 | One-cycle result strobe |
| error_o | output | 1 | Zero-slot or mirror check failed |
| result_o | output | 12 | Left-aligned two's-complement result |
| result_sx_o | output | 16 | Result sign-extended |

## Verification
Two events can fall in the same cycle: a new start request, and the end of a frame (valid pulse, select rising, guard starting). To force this, the bench holds start_i high across a whole frame. It then checks that each frame gives exactly one valid pulse and that the select-high gap before the following frame is at least one serial-clock period. A start pulse in the middle of a frame must leave the valid and select-fall counts unchanged. The second overlap is in the error flag, which must be set whether the fault comes from the zero slot or from the mirror comparison.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int RES         = 12;
  localparam int SX_W        = 16;
  localparam int ZERO_SLOT   = 3;
  localparam int LAST_DATA   = ZERO_SLOT + RES;
  localparam int LAST_MIRROR = LAST_DATA + RES - 1;
  localparam int MIN_BITS    = 3;
  localparam int SLOT_W      = $clog2(LAST_MIRROR + 1);
  localparam int NB_W        = $clog2(RES + 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_GUARD} sq_state_e;
endpackage

// File: rtl/scr_rstsync.sv
module scr_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/scr_halfdiv.sv
module scr_halfdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_max,
  output logic             half_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    half_tick = run && (cnt_q == div_max);
    if (!run || half_tick) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scr_seq.sv
module scr_seq
  import scr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              mirror_i,
  input  logic              half_tick,
  output logic              run,
  output logic [DIV_W-1:0]  div_q,
  output logic              cs_n,
  output logic              sclk,
  output logic              load,
  output logic              rise_evt,
  output logic [SLOT_W-1:0] rise_idx,
  output logic              end_evt,
  output logic              busy
);
  localparam logic [NB_W-1:0]   NB_MIN   = NB_W'(MIN_BITS);
  localparam logic [NB_W-1:0]   NB_MAX   = NB_W'(RES);
  localparam logic [SLOT_W-1:0] SLOT_ZERO = SLOT_W'(ZERO_SLOT);
  localparam logic [SLOT_W-1:0] SLOT_MIR  = SLOT_W'(LAST_MIRROR);

  sq_state_e         state_q, state_d;
  logic              cs_n_q, cs_n_d;
  logic              sclk_q, sclk_d;
  logic [SLOT_W-1:0] rcnt_q, rcnt_d;
  logic [SLOT_W-1:0] last_q, last_d;
  logic              gdone_q, gdone_d;
  logic [DIV_W-1:0]  div_d;
  logic [NB_W-1:0]   nb_eff;
  logic [SLOT_W-1:0] last_new;

  always_comb begin
    if (nbits_i < NB_MIN)      nb_eff = NB_MIN;
    else if (nbits_i > NB_MAX) nb_eff = NB_MAX;
    else                       nb_eff = nbits_i;
    if (mirror_i && (nb_eff == NB_MAX)) last_new = SLOT_MIR;
    else                                last_new = SLOT_ZERO + SLOT_W'(nb_eff);
  end

  always_comb begin
    load     = (state_q == SQ_IDLE) && start_i;
    rise_evt = (state_q == SQ_RUN) && half_tick && !sclk_q;
    rise_idx = rcnt_q + 1'b1;
    end_evt  = (state_q == SQ_RUN) && half_tick && sclk_q && (rcnt_q == last_q);
    run      = (state_q != SQ_IDLE);
    busy     = run;
    cs_n     = cs_n_q;
    sclk     = sclk_q;
  end

  always_comb begin
    state_d = state_q;
    cs_n_d  = cs_n_q;
    sclk_d  = sclk_q;
    rcnt_d  = rcnt_q;
    last_d  = last_q;
    gdone_d = gdone_q;
    div_d   = div_q;
    case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          state_d = SQ_RUN;
          cs_n_d  = 1'b0;
          sclk_d  = 1'b0;
          rcnt_d  = '0;
          div_d   = div_i;
          last_d  = last_new;
        end
      end
      SQ_RUN: begin
        if (half_tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            rcnt_d = rise_idx;
          end else begin
            sclk_d = 1'b0;
            if (rcnt_q == last_q) begin
              cs_n_d  = 1'b1;
              state_d = SQ_GUARD;
              gdone_d = 1'b0;
            end
          end
        end
      end
      SQ_GUARD: begin
        if (half_tick) begin
          gdone_d = 1'b1;
          if (gdone_q) state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      rcnt_q  <= '0;
      last_q  <= '0;
      gdone_q <= 1'b0;
      div_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      rcnt_q  <= rcnt_d;
      last_q  <= last_d;
      gdone_q <= gdone_d;
      div_q   <= div_d;
    end
  end
endmodule

// File: rtl/scr_capture.sv
module scr_capture
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise_evt,
  input  logic [SLOT_W-1:0] rise_idx,
  input  logic              sdata_i,
  output logic [RES-1:0]    word,
  output logic              err
);
  logic [RES-1:0] word_q, word_d;
  logic [RES-1:0] mis_hit;
  logic           zero_hit;
  logic           err_q, err_d;

  for (genvar i = 0; i < RES; i++) begin : g_bit
    localparam logic [SLOT_W-1:0] DATA_SLOT = SLOT_W'(LAST_DATA - i);
    always_comb begin
      if (clear)                                   word_d[i] = 1'b0;
      else if (rise_evt && (rise_idx == DATA_SLOT)) word_d[i] = sdata_i;
      else                                         word_d[i] = word_q[i];
    end
    if (i == 0) begin : g_shared
      assign mis_hit[i] = 1'b0;
    end else begin : g_mirror
      localparam logic [SLOT_W-1:0] MIR_SLOT = SLOT_W'(LAST_DATA + i);
      assign mis_hit[i] = rise_evt && (rise_idx == MIR_SLOT) && (sdata_i != word_q[i]);
    end
  end

  always_comb begin
    zero_hit = rise_evt && (rise_idx == SLOT_W'(ZERO_SLOT)) && sdata_i;
    if (clear) err_d = 1'b0;
    else       err_d = err_q | zero_hit | (|mis_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      err_q  <= err_d;
    end
  end

  assign word = word_q;
  assign err  = err_q;
endmodule

// File: rtl/scr_reader.sv
module scr_reader
  import scr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              mirror_i,
  input  logic              sdata_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic              error_o,
  output logic [RES-1:0]    result_o,
  output logic [SX_W-1:0]   result_sx_o
);
  logic              rst_n_s;
  logic              half_tick, run, load, rise_evt, end_evt;
  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] rise_idx;
  logic [RES-1:0]    word;
  logic              cap_err;
  logic [RES-1:0]    result_q, result_d;
  logic              err_q, err_d;
  logic              valid_q;

  scr_rstsync i_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  scr_halfdiv #(.DIV_W(DIV_W)) i_div (
    .clk(clk), .rst_n(rst_n_s), .run(run), .div_max(div_q), .half_tick(half_tick)
  );

  scr_seq #(.DIV_W(DIV_W)) i_seq (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i), .div_i(div_i), .nbits_i(nbits_i),
    .mirror_i(mirror_i), .half_tick(half_tick), .run(run), .div_q(div_q),
    .cs_n(cs_n_o), .sclk(sclk_o), .load(load), .rise_evt(rise_evt),
    .rise_idx(rise_idx), .end_evt(end_evt), .busy(busy_o)
  );

  scr_capture i_cap (
    .clk(clk), .rst_n(rst_n_s), .clear(load), .rise_evt(rise_evt),
    .rise_idx(rise_idx), .sdata_i(sdata_i), .word(word), .err(cap_err)
  );

  always_comb begin
    result_d = end_evt ? word    : result_q;
    err_d    = end_evt ? cap_err : err_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      result_q <= '0;
      err_q    <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      err_q    <= err_d;
      valid_q  <= end_evt;
    end
  end

  assign valid_o     = valid_q;
  assign error_o     = err_q;
  assign result_o    = result_q;
  assign result_sx_o = {{(SX_W-RES){result_q[RES-1]}}, result_q};
endmodule

// File: rtl/scr_reader_chk.sv
module scr_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        cs_n_o,
  input logic        sclk_o,
  input logic        busy_o,
  input logic        valid_o,
  input logic [11:0] result_o
);
  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_valid_at_cs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(cs_n_o));

  p_result_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));

  p_start_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));
endmodule

bind scr_reader scr_reader_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .busy_o(busy_o), .valid_o(valid_o), .result_o(result_o)
);

// File: tb/test_scr_reader.sv
`timescale 1ns/1ps
module test_scr_reader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  div_i;
  logic [3:0]  nbits_i;
  logic        mirror_i;
  logic        sdata_i;
  logic        cs_n_o, sclk_o, busy_o, valid_o, error_o;
  logic [11:0] result_o;
  logic [15:0] result_sx_o;

  int vectors = 0;
  int fails   = 0;

  int  dev_code;
  bit  dev_bz, dev_bm;
  int  fcnt, rise_cnt, cs_falls, valid_cnt;
  real t_csfall, t_csrise, t_r1, t_r2, gap_ns;

  always #2.5 clk = ~clk;

  scr_reader i_scr_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i), .nbits_i(nbits_i),
    .mirror_i(mirror_i), .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .busy_o(busy_o), .valid_o(valid_o), .error_o(error_o), .result_o(result_o),
    .result_sx_o(result_sx_o)
  );

  // converter model: data changes on falling serial clock
  always @(negedge cs_n_o) begin
    fcnt = 0; rise_cnt = 0; sdata_i = 1'b1;
    gap_ns = $realtime - t_csrise; t_csfall = $realtime; cs_falls++;
  end
  always @(posedge cs_n_o) begin
    t_csrise = $realtime; sdata_i = 1'b1;
  end
  always @(negedge sclk_o) if (!cs_n_o) begin
    fcnt++;
    if (fcnt == 2)                    sdata_i = dev_bz;
    else if (fcnt >= 3 && fcnt <= 14) sdata_i = dev_code[14-fcnt];
    else if (fcnt >= 15 && fcnt <= 25) sdata_i = dev_code[fcnt-14] ^ (dev_bm && fcnt == 20);
    else                              sdata_i = 1'b1;
  end
  always @(posedge sclk_o) if (!cs_n_o) begin
    rise_cnt++;
    if (rise_cnt == 1) t_r1 = $realtime;
    if (rise_cnt == 2) t_r2 = $realtime;
  end
  always @(negedge clk) if (valid_o === 1'b1) valid_cnt++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    while (valid_o !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, req, "valid timeout", n, 0);
  endtask

  task automatic run_conv(input int code, input int dv, input int nb, input bit mir,
                          input bit bz, input bit bm, input string req);
    int nbe, em, sx, rexp;
    bit eexp;
    dev_code = code; dev_bz = bz; dev_bm = bm;
    @(negedge clk);
    div_i = 8'(dv); nbits_i = 4'(nb); mirror_i = mir; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_valid(req);
    nbe  = (nb < 3) ? 3 : ((nb > 12) ? 12 : nb);
    em   = code & ((12'hFFF << (12 - nbe)) & 12'hFFF);
    sx   = (em & 12'h800) ? (em | 16'hF000) : em;
    rexp = (mir && nbe == 12) ? 26 : 3 + nbe;
    eexp = bz || (mir && nbe == 12 && bm);
    chk(result_o == 12'(em), req, "result", int'(result_o), em);
    chk(result_sx_o == 16'(sx), "R3", "sign-extended", int'(result_sx_o), sx);
    chk(error_o == eexp, req, "error", int'(error_o), int'(eexp));
    chk(rise_cnt == rexp, "R4", "rising edges", rise_cnt, rexp);
    @(negedge clk);
    chk(valid_o == 1'b0, "R7", "valid width", int'(valid_o), 0);
    while (busy_o) @(negedge clk);
    chk(result_o == 12'(em), "R7", "result held", int'(result_o), em);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int v0, c0, hp;
    rst_n = 1'b0; start_i = 1'b0; div_i = '0; nbits_i = 4'd12; mirror_i = 1'b0; sdata_i = 1'b1;
    cs_falls = 0; valid_cnt = 0; t_csrise = 0.0; dev_bz = 0; dev_bm = 0; dev_code = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n_o == 1'b1 && sclk_o == 1'b0, "R1", "cs/sclk", {cs_n_o, sclk_o}, 2'b10);
    chk(!busy_o && !valid_o && !error_o, "R1", "flags", {busy_o, valid_o, error_o}, 0);
    chk(result_o == 0 && result_sx_o == 0, "R1", "result", int'(result_sx_o), 0);

    // R3 code sweep, full frames, mirror alternating (R5)
    for (int c = 0; c < 4096; c += 13) run_conv(c, 0, 12, c[0], 0, 0, "R3");
    run_conv(12'h800, 0, 12, 1, 0, 0, "R3");
    run_conv(12'h7FF, 0, 12, 1, 0, 0, "R3");
    run_conv(12'hFFF, 1, 12, 0, 0, 0, "R3");

    // R4 bit-count sweep including clamped values
    for (int n = 0; n < 16; n++) run_conv(12'hA5C, 1, n, 0, 0, 0, "R4");
    // R5 mirror ignored when short, mirror mismatch detected when full
    for (int n = 3; n < 12; n++) run_conv(12'h3C7, 0, n, 1, 0, 1, "R5");
    run_conv(12'h3C7, 0, 12, 1, 0, 1, "R5");
    run_conv(12'h3C7, 0, 12, 0, 0, 1, "R5");
    // R6 zero slot reads one
    run_conv(12'h155, 0, 12, 0, 1, 0, "R6");
    run_conv(12'h155, 0, 4, 0, 1, 0, "R6");
    run_conv(12'h155, 0, 12, 0, 0, 0, "R6");

    // R2 half-period timing
    for (int d = 0; d < 6; d++) begin
      run_conv(12'h9A1, d, 12, 0, 0, 0, "R2");
      hp = $rtoi((t_r1 - t_csfall) / 5.0 + 0.5);
      chk(hp == d + 1, "R2", "first rise delay", hp, d + 1);
      hp = $rtoi((t_r2 - t_r1) / 5.0 + 0.5);
      chk(hp == 2 * (d + 1), "R2", "sclk period", hp, 2 * (d + 1));
    end

    // R8 start during a frame is dropped
    v0 = valid_cnt; c0 = cs_falls;
    dev_code = 12'h4D2; dev_bz = 0; dev_bm = 0;
    @(negedge clk); div_i = 8'd2; nbits_i = 4'd12; mirror_i = 1'b0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (rise_cnt < 5) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    wait_valid("R8");
    repeat (200) @(negedge clk);
    chk(valid_cnt - v0 == 1, "R8", "valid count", valid_cnt - v0, 1);
    chk(cs_falls - c0 == 1, "R8", "cs falls", cs_falls - c0, 1);

    // R8 start held through frame end: guard gap
    for (int d = 0; d < 3; d++) begin
      v0 = valid_cnt; c0 = cs_falls;
      dev_code = 12'h6E9;
      @(negedge clk); div_i = 8'(d); start_i = 1'b1;
      while (cs_falls - c0 < 2) @(negedge clk);
      hp = $rtoi(gap_ns / 5.0 + 0.5);
      chk(hp >= 2 * (d + 1), "R8", "cs high gap", hp, 2 * (d + 1));
      start_i = 1'b0;
      while (busy_o) @(negedge clk);
      chk(valid_cnt - v0 == 2, "R7", "one valid per frame", valid_cnt - v0, 2);
      chk(result_o == 12'h6E9, "R3", "back-to-back result", int'(result_o), 12'h6E9);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule